// File: doc/BRIEF.md
# Two-Byte Word I2C Target

This block is an I2C target that runs on the system clock. It samples the SCL and SDA bus lines and pulls SDA low through an output-enable, so the pad can work as an open-drain driver. Both lines first pass a synchronizer and then a spike filter that is set in system clocks. After the filter, START and STOP conditions and the clock edges are recovered from the two lines.

The 7-bit target address is built from a fixed upper field and a group of strap inputs. By default the upper field is 1010 and three straps give the low bits, so up to eight of these targets can share one bus. The transfers have a fixed shape:

- A write carries exactly two data bytes. The block presents them as one 16-bit word, first byte in the upper half, with a valid pulse one clock wide.
- A read returns a 16-bit status word as two bytes. The word is captured when the address byte is acknowledged.

The meaning of the bytes belongs to the logic that uses the word.

Top module: `i2c_word_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START seen at any point, including a repeated START in the middle of a frame, restarts address reception and drops any partial write word.
- R2: The target matches address {4'b1010, strap[2], strap[1], strap[0]}, MSB first, followed by the R/W bit (1 = read, 0 = write). On a match it holds SDA low during the ninth clock of the address byte. On a mismatch it does not acknowledge and leaves SDA released until the next START.
- R3: In a write, each data byte is acknowledged. After the acknowledge clock of the second byte ends, `word_valid` is high for exactly one clock and `word_out` = {first byte, second byte}.
- R4: Write bytes after the second are still acknowledged. They produce no further `word_valid` pulse.
- R5: A write frame that ends with STOP after one data byte produces no `word_valid` pulse.
- R6: A read sends `status_in[15:8]` and then `status_in[7:0]`, each MSB first. The value is taken at the acknowledge of the address byte, so changes to `status_in` after that point do not affect the bytes sent.
- R7: When the master leaves SDA high (NACK) in the acknowledge slot of a read byte, the target releases SDA. Any further clocks before STOP read back as all ones.
- R8: A pulse on SCL or SDA shorter than FILT_LEN system clocks (default 4) is ignored. It creates no bit, no START and no STOP.
- R9: The target changes its SDA drive only while SCL is low.
- R10: After reset the target does not drive SDA and `word_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| strap | input | PIN_W (3) | Low bits of the target address |
| status_in | input | 8*NBYTES (16) | Status word returned by reads |
| word_out | output | 8*NBYTES (16) | Last complete write word |
| word_valid | output | 1 | One-clock strobe for a new word_out |

## Verification
The write path is driven with several byte pairs: complementary values, all-zero and all-one halves, and a nibble pattern. These show whether the bytes are ordered correctly and whether every bit lands in its place.

Other patterns check the framing rules, with the strobe count as the observed result:
- a third trailing byte,
- a single byte followed by STOP,
- a repeated START after one byte,
- a foreign address.

Reads use a status value that is changed right after the address acknowledge, which shows whether the word was captured at the right moment. Reads are also followed by clocks after the master's NACK. A write frame with short spikes placed on both lines separates correct filtering from false bits and false START/STOP conditions.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WBYTE,
      ST_WACK,
      ST_RBYTE,
      ST_RACK
   } tgt_state_t;
endpackage

// File: rtl/i2cw_line_filter.sv
module i2cw_line_filter #(
   parameter int   FILT_LEN  = 4,
   parameter int   FILT_KIND = 0,
   parameter logic RST_VAL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int CNT_W = $clog2(FILT_LEN + 1);

   if (FILT_LEN < 1) begin : g_bad_len
      $error("i2cw_line_filter: FILT_LEN must be at least 1");
   end
   if (FILT_KIND != 0 && FILT_KIND != 1) begin : g_bad_kind
      $error("i2cw_line_filter: FILT_KIND must be 0 or 1");
   end

   logic [1:0] sync_q;
   logic       samp;
   logic       clean_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {2{RST_VAL}};
      else        sync_q <= {sync_q[0], raw_i};
   end
   assign samp = sync_q[1];

   if (FILT_KIND == 0) begin : g_holdoff
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            clean_q <= RST_VAL;
         end else if (samp != clean_q) begin
            if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
               clean_q <= samp;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end

      // R8
      filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(clean_q) |-> ($past(samp) == clean_q));
   end else begin : g_majority
      logic [2:0] hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q  <= {3{RST_VAL}};
            clean_q <= RST_VAL;
         end else begin
            hist_q  <= {hist_q[1:0], samp};
            clean_q <= (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) |
                       (hist_q[0] & hist_q[2]);
         end
      end
   end

   assign clean_o = clean_q;
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev,
   output logic scl_lvl,
   output logic sda_lvl
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
   assign scl_lvl  = scl_f;
   assign sda_lvl  = sda_f;
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
   import i2cw_pkg::*;
#(
   parameter int         PIN_W     = 3,
   parameter logic [6:0] ADDR_BASE = 7'h50,
   parameter int         NBYTES    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_rise,
   input  logic                       scl_fall,
   input  logic                       start_ev,
   input  logic                       stop_ev,
   input  logic                       scl_lvl,
   input  logic                       sda_lvl,
   input  logic [PIN_W-1:0]           strap,
   input  logic [NBYTES*BYTE_W-1:0]   status_in,
   output logic                       sda_pull,
   output logic [NBYTES*BYTE_W-1:0]   word_out,
   output logic                       word_valid
);
   localparam int         WORD_W   = NBYTES * BYTE_W;
   localparam int         IDX_W    = $clog2(NBYTES + 1);
   localparam logic [3:0] BIT_LAST = 4'd8;

   if (NBYTES < 2) begin : g_bad_nbytes
      $error("i2cw_engine: NBYTES must be at least 2");
   end
   if (PIN_W < 1 || PIN_W > 6) begin : g_bad_pins
      $error("i2cw_engine: PIN_W must be 1..6");
   end

   logic [6:0] own_addr;
   assign own_addr = {ADDR_BASE[6:PIN_W], strap};

   tgt_state_t        state_q;
   logic [3:0]        bitcnt_q;
   logic [BYTE_W-1:0] rx_q;
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic              rw_q, mack_q, pull_q, valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         rx_q     <= '0;
         acc_q    <= '0;
         tx_q     <= '0;
         word_q   <= '0;
         idx_q    <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         pull_q   <= 1'b0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (start_ev) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            idx_q    <= '0;
            pull_q   <= 1'b0;
         end else if (stop_ev) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_WBYTE: begin
                  if (scl_rise) begin
                     rx_q     <= {rx_q[BYTE_W-2:0], sda_lvl};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall && bitcnt_q == BIT_LAST) begin
                     bitcnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (rx_q[7:1] == own_addr) begin
                           pull_q  <= 1'b1;
                           rw_q    <= rx_q[0];
                           tx_q    <= status_in;
                           state_q <= ST_AACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else begin
                        pull_q  <= 1'b1;
                        state_q <= ST_WACK;
                        if (idx_q < IDX_W'(NBYTES))
                           acc_q <= {acc_q[WORD_W-BYTE_W-1:0], rx_q};
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        pull_q  <= ~tx_q[WORD_W-1];
                        state_q <= ST_RBYTE;
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= ST_WBYTE;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     pull_q  <= 1'b0;
                     state_q <= ST_WBYTE;
                     if (idx_q == IDX_W'(NBYTES - 1)) begin
                        valid_q <= 1'b1;
                        word_q  <= acc_q;
                     end
                     if (idx_q < IDX_W'(NBYTES)) idx_q <= idx_q + 1'b1;
                  end
               end
               ST_RBYTE: begin
                  if (scl_rise) begin
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt_q == BIT_LAST) begin
                        pull_q   <= 1'b0;
                        bitcnt_q <= '0;
                        state_q  <= ST_RACK;
                     end else begin
                        tx_q   <= tx_q << 1;
                        pull_q <= ~tx_q[WORD_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_q    <= tx_q << 1;
                        pull_q  <= ~tx_q[WORD_W-2];
                        state_q <= ST_RBYTE;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull   = pull_q;
   assign word_out   = word_q;
   assign word_valid = valid_q;

   // R9
   pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull_q) |-> !scl_lvl);
   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   // R3
   strobe_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(pull_q));
   // R1
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !pull_q);
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target #(
   parameter int         PIN_W     = 3,
   parameter logic [6:0] ADDR_BASE = 7'h50,
   parameter int         NBYTES    = 2,
   parameter int         FILT_LEN  = 4,
   parameter int         FILT_KIND = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_in,
   input  logic                 sda_in,
   output logic                 sda_pull,
   input  logic [PIN_W-1:0]     strap,
   input  logic [NBYTES*8-1:0]  status_in,
   output logic [NBYTES*8-1:0]  word_out,
   output logic                 word_valid
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw_lines, clean_lines;
   logic scl_rise, scl_fall, start_ev, stop_ev, scl_lvl, sda_lvl;

   assign raw_lines = {sda_in, scl_in};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2cw_line_filter #(
         .FILT_LEN (FILT_LEN),
         .FILT_KIND(FILT_KIND),
         .RST_VAL  (1'b1)
      ) i_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw_lines[g]),
         .clean_o(clean_lines[g])
      );
   end

   i2cw_bus_events i_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (clean_lines[0]),
      .sda_f   (clean_lines[1]),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev),
      .scl_lvl (scl_lvl),
      .sda_lvl (sda_lvl)
   );

   i2cw_engine #(
      .PIN_W    (PIN_W),
      .ADDR_BASE(ADDR_BASE),
      .NBYTES   (NBYTES)
   ) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_ev  (start_ev),
      .stop_ev   (stop_ev),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .strap     (strap),
      .status_in (status_in),
      .sda_pull  (sda_pull),
      .word_out  (word_out),
      .word_valid(word_valid)
   );
endmodule

// File: tb/test_i2c_word_target.sv
module test_i2c_word_target;
   localparam int CLK_PERIOD = 10;
   localparam int QT = 16;
   localparam int HT = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull;
   logic [2:0]  strap = 3'b101;
   logic [15:0] status_in = 16'h0000;
   logic [15:0] word_out;
   logic        word_valid;
   wire         sda_bus = sda_m & ~sda_pull;

   int checks = 0;
   int fails = 0;
   int strobes = 0;
   logic [15:0] got_word = '0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_word_target i_i2c_word_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_m),
      .sda_in    (sda_bus),
      .sda_pull  (sda_pull),
      .strap     (strap),
      .status_in (status_in),
      .word_out  (word_out),
      .word_valid(word_valid)
   );

   always @(posedge clk) begin
      if (rst_n && word_valid) begin
         strobes  <= strobes + 1;
         got_word <= word_out;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(QT);
      scl_m = 1'b1; wait_clk(HT);
      sda_m = 1'b0; wait_clk(HT);
      scl_m = 1'b0; wait_clk(QT);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(QT);
      scl_m = 1'b1; wait_clk(HT);
      sda_m = 1'b1; wait_clk(HT);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit spikes, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i];
         if (spikes) begin
            wait_clk(4); scl_m = 1'b1; wait_clk(2); scl_m = 1'b0; wait_clk(QT - 6);
         end else wait_clk(QT);
         scl_m = 1'b1;
         if (spikes) begin
            wait_clk(8); sda_m = ~sda_m; wait_clk(2); sda_m = ~sda_m; wait_clk(HT - 10);
         end else wait_clk(HT);
         scl_m = 1'b0; wait_clk(QT);
      end
      sda_m = 1'b1; wait_clk(QT);
      scl_m = 1'b1; wait_clk(HT/2);
      ack = ~sda_bus;
      wait_clk(HT/2);
      scl_m = 1'b0; wait_clk(QT);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wait_clk(QT);
         scl_m = 1'b1; wait_clk(HT/2);
         b[i] = sda_bus;
         wait_clk(HT/2);
         scl_m = 1'b0; wait_clk(QT);
      end
      sda_m = ~mack; wait_clk(QT);
      scl_m = 1'b1; wait_clk(HT);
      scl_m = 1'b0; wait_clk(QT);
   endtask

   task automatic t_reset();
      chk("R10 sda_pull after reset", {15'd0, sda_pull}, 16'd0);
      chk("R10 word_valid after reset", {15'd0, word_valid}, 16'd0);
   endtask

   task automatic t_write(input logic [7:0] b0, input logic [7:0] b1, input bit spikes, input string tag);
      bit a;
      int s0 = strobes;
      bus_start();
      send_byte(8'hAA, spikes, a); chk({tag, " address ack"}, {15'd0, a}, 16'd1);
      send_byte(b0, spikes, a);    chk({tag, " byte0 ack"}, {15'd0, a}, 16'd1);
      send_byte(b1, spikes, a);    chk({tag, " byte1 ack"}, {15'd0, a}, 16'd1);
      bus_stop();
      chk({tag, " one strobe"}, 16'(strobes - s0), 16'd1);
      chk({tag, " word"}, got_word, {b0, b1});
   endtask

   task automatic t_extra();
      bit a;
      int s0 = strobes;
      bus_start();
      send_byte(8'hAA, 1'b0, a);
      send_byte(8'h12, 1'b0, a);
      send_byte(8'h34, 1'b0, a);
      send_byte(8'h56, 1'b0, a);
      chk("R4 third byte ack", {15'd0, a}, 16'd1);
      bus_stop();
      chk("R4 single strobe", 16'(strobes - s0), 16'd1);
      chk("R4 word keeps first two bytes", got_word, 16'h1234);
   endtask

   task automatic t_short();
      bit a;
      int s0 = strobes;
      bus_start();
      send_byte(8'hAA, 1'b0, a);
      send_byte(8'h77, 1'b0, a);
      bus_stop();
      wait_clk(20);
      chk("R5 no strobe on one-byte frame", 16'(strobes - s0), 16'd0);
   endtask

   task automatic t_mismatch();
      bit a;
      int s0 = strobes;
      bus_start();
      send_byte(8'hAE, 1'b0, a); chk("R2 foreign address no ack", {15'd0, a}, 16'd0);
      send_byte(8'h11, 1'b0, a); chk("R2 released after mismatch", {15'd0, a}, 16'd0);
      send_byte(8'h22, 1'b0, a);
      bus_stop();
      chk("R2 no strobe after mismatch", 16'(strobes - s0), 16'd0);
   endtask

   task automatic t_restart();
      bit a;
      int s0 = strobes;
      bus_start();
      send_byte(8'hAA, 1'b0, a);
      send_byte(8'h9E, 1'b0, a);
      bus_start();
      send_byte(8'hAA, 1'b0, a); chk("R1 ack after repeated start", {15'd0, a}, 16'd1);
      send_byte(8'h21, 1'b0, a);
      send_byte(8'h43, 1'b0, a);
      bus_stop();
      chk("R1 one strobe after restart", 16'(strobes - s0), 16'd1);
      chk("R1 word after restart", got_word, 16'h2143);
   endtask

   task automatic t_read();
      bit a;
      logic [7:0] hi, lo, tail;
      status_in = 16'hA55A;
      bus_start();
      send_byte(8'hAB, 1'b0, a); chk("R2 read address ack", {15'd0, a}, 16'd1);
      status_in = 16'h0FF0;
      recv_byte(1'b1, hi); chk("R6 read high byte", {8'd0, hi}, 16'h00A5);
      recv_byte(1'b0, lo); chk("R6 read low byte latched", {8'd0, lo}, 16'h005A);
      recv_byte(1'b0, tail); chk("R7 released after NACK", {8'd0, tail}, 16'h00FF);
      bus_stop();
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_write(8'h3C, 8'hC3, 1'b0, "R3 pattern 3C/C3");
      t_write(8'h00, 8'hFF, 1'b0, "R3 pattern 00/FF");
      t_write(8'hF0, 8'h0F, 1'b0, "R3 pattern F0/0F");
      t_extra();
      t_short();
      t_mismatch();
      t_restart();
      t_read();
      t_write(8'h5A, 8'h96, 1'b1, "R8 spikes on both lines");
      wait_clk(10);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule